// File: doc/BRIEF.md
# PLL Coefficient Search Engine

This block picks integer divider settings for a phase-locked loop. A request carries a reference frequency and a wanted output frequency, both in kHz, and a mode bit. The engine then searches for a pre-divider M, a feedback multiplier N and a post-divider PL whose output, ref × N / (M × PL), comes closest to the wanted frequency. Every candidate must keep the update rate ref / M and the VCO rate ref × N / M inside fixed windows. The M, N and PL ranges, both windows and the tolerance ratio are elaboration parameters.

The search does not try every combination. The PL range is first narrowed from a VCO target that carries a 2 % margin. The M loop stops once the update rate drops too low, or once the smallest N candidate passes the N ceiling. At most two N candidates are tried for each (PL, M) pair: the floor and the ceiling of the ideal value. The search ends at once on an exact hit. In tolerant mode it also ends on the first improving candidate that is close enough. A single iterative divider does every quotient, and the engine waits for it each time.

Requests enter on a valid/ready pair. `req_ready` is high only while the engine is idle, so a request is taken on a clock edge where `req_valid` and `req_ready` are both high, and it must be held until then. The result leaves on a second valid/ready pair. While `res_valid` is high and `res_ready` is low, every result field holds still. The engine takes no new request until the result has been taken.

Top module: `pll_coef_search`

## Requirements
- R1: After reset, `req_ready` is 1 and `res_valid` is 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. From the next cycle `req_ready` stays 0 until the result handshake completes.
- R3: While `res_valid` is 1 and `res_ready` is 0, `res_valid` stays 1 and all result fields keep their values.
- R4: A candidate whose rounded output equals the target ends the search at once and is returned.
- R5: The PL range is [floor(VCO_MIN / t), ceil(vmax / t)], clamped to [PL_MIN, PL_MAX]. Here t = target + floor(target / 50), and vmax = max(VCO_MAX, t). The raised vmax is also the upper end of the VCO window.
- R6: For each PL, M counts up from M_MIN and u = floor(ref / M). If u < U_MIN, that PL's M loop ends. If u > U_MAX, that M is skipped.
- R7: For each (PL, M), the N candidates run from floor to ceil of target × PL × M / ref. Candidates below N_MIN are skipped. The M loop ends once the floor value exceeds N_MAX. A candidate counts only if floor(ref × N / M) lies in [VCO_MIN, vmax].
- R8: The error of a candidate is |floor((vco + floor(PL / 2)) / PL) − target|. Only a strictly smaller error replaces the best so far, so the first candidate found wins a tie.
- R9: With `req_best_fit` = 0, the search ends at the first improving candidate where floor(vco / error) > TOL (218 by default).
- R10: `res_freq_khz` = floor(ref × N / (M × PL)) for the returned M, N and PL.
- R11: `res_inexact` is 1 only when best-fit mode returns a nonzero error.
- R12: If no candidate qualifies, the result carries `res_none` = 1, `res_freq_khz` = 0 and `res_inexact` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_ref_khz | input | FW | Reference frequency in kHz |
| req_tgt_khz | input | FW | Wanted output frequency in kHz |
| req_best_fit | input | 1 | 1: search until exact or exhausted; 0: stop at tolerance |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes result |
| res_m | output | MW | Chosen pre-divider |
| res_n | output | NW | Chosen feedback multiplier |
| res_pl | output | PW | Chosen post-divider |
| res_freq_khz | output | FW | Resulting output frequency in kHz |
| res_inexact | output | 1 | Best-fit mode ended with nonzero error |
| res_none | output | 1 | No candidate met the limits |

## Verification
The bench builds the block with its default limits: M and N up to 255, PL from 1 to 31, a 1.3 to 2.6 GHz VCO window, a 12 to 38.4 MHz update window and a tolerance of 218. With a 38.4 MHz reference, these limits reach an exact hit on the first candidate. They also reach targets where tolerant and best-fit modes return different (M, N, PL). One target sits at the VCO ceiling, so the raised VCO bound decides which N is taken. A 50 MHz reference forces the too-fast update rate to skip M = 1. A 10 MHz reference leaves no candidate at all.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef enum logic [4:0] {
    ST_IDLE, ST_WAIT,
    ST_D_MARGIN, ST_A_MARGIN,
    ST_D_HIGH, ST_A_HIGH,
    ST_D_LOW, ST_A_LOW,
    ST_D_U, ST_A_U,
    ST_NEXT_M, ST_NEXT_PL,
    ST_D_N, ST_A_N,
    ST_D_VCO, ST_A_VCO,
    ST_D_LWV, ST_A_LWV,
    ST_FIN, ST_A_FREQ, ST_OUT
  } pcs_state_e;
endpackage

// File: rtl/pcs_divider.sv
module pcs_divider #(
  parameter int unsigned DW = 37
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          done,
  output logic [DW-1:0] quo,
  output logic [DW-1:0] rem
);
  localparam int unsigned CW = $clog2(DW + 1);

  logic [CW-1:0] cnt;
  logic [DW-1:0] den_r;
  logic [DW:0]   shifted;
  logic          fits;

  assign shifted = {rem, quo[DW-1]};
  assign fits    = shifted >= {1'b0, den_r};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      den_r <= '0;
      quo   <= '0;
      rem   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        quo   <= num;
        rem   <= '0;
        den_r <= den;
        cnt   <= CW'(DW);
      end else if (cnt != '0) begin
        if (fits) begin
          rem <= DW'(shifted - {1'b0, den_r});
          quo <= {quo[DW-2:0], 1'b1};
        end else begin
          rem <= shifted[DW-1:0];
          quo <= {quo[DW-2:0], 1'b0};
        end
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pcs_engine.sv
module pcs_engine
  import pcs_pkg::*;
#(
  parameter int unsigned FW      = 22,
  parameter int unsigned MW      = 8,
  parameter int unsigned NW      = 8,
  parameter int unsigned PW      = 5,
  parameter int unsigned DW      = 37,
  parameter int unsigned M_MIN   = 1,
  parameter int unsigned M_MAX   = 255,
  parameter int unsigned N_MIN   = 8,
  parameter int unsigned N_MAX   = 255,
  parameter int unsigned PL_MIN  = 1,
  parameter int unsigned PL_MAX  = 31,
  parameter int unsigned VCO_MIN = 1300000,
  parameter int unsigned VCO_MAX = 2600000,
  parameter int unsigned U_MIN   = 12000,
  parameter int unsigned U_MAX   = 38400,
  parameter int unsigned TOL     = 218
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [FW-1:0] req_ref_khz,
  input  logic [FW-1:0] req_tgt_khz,
  input  logic          req_best_fit,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [MW-1:0] res_m,
  output logic [NW-1:0] res_n,
  output logic [PW-1:0] res_pl,
  output logic [FW-1:0] res_freq_khz,
  output logic          res_inexact,
  output logic          res_none,
  output logic          div_start,
  output logic [DW-1:0] div_num,
  output logic [DW-1:0] div_den,
  input  logic          div_done,
  input  logic [DW-1:0] div_quo,
  input  logic [DW-1:0] div_rem
);
  localparam int unsigned XW = DW + 9;
  localparam logic [DW-1:0] VMIN_D  = DW'(VCO_MIN);
  localparam logic [DW-1:0] VMAX_D  = DW'(VCO_MAX);
  localparam logic [XW-1:0] STOP_K  = XW'(TOL + 1);

  pcs_state_e state, ret;
  logic [DW-1:0] ref_r, tgt_r, tvco, vmax, n, n2, vco, bdelta, delta;
  logic [PW:0]   pl, hi;
  logic [MW:0]   m;
  logic          bf_r, found;
  logic [MW-1:0] bm;
  logic [NW-1:0] bn;
  logic [PW-1:0] bpl;
  logic [FW-1:0] freq;
  logic [DW-1:0] ceil_q;

  assign ceil_q = div_quo + DW'(div_rem != '0);
  assign delta  = (div_quo >= tgt_r) ? div_quo - tgt_r : tgt_r - div_quo;

  function automatic logic [PW:0] clamp_pl(input logic [DW-1:0] v);
    if (v > DW'(PL_MAX))      return (PW+1)'(PL_MAX);
    else if (v < DW'(PL_MIN)) return (PW+1)'(PL_MIN);
    else                      return v[PW:0];
  endfunction

  assign req_ready    = (state == ST_IDLE);
  assign res_valid    = (state == ST_OUT);
  assign res_m        = bm;
  assign res_n        = bn;
  assign res_pl       = bpl;
  assign res_freq_khz = freq;
  assign res_none     = !found;
  assign res_inexact  = found && bf_r && (bdelta != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; ret <= ST_IDLE;
      ref_r <= '0; tgt_r <= '0; tvco <= '0; vmax <= '0;
      n <= '0; n2 <= '0; vco <= '0; bdelta <= '1;
      pl <= '0; hi <= '0; m <= '0; bf_r <= 1'b0; found <= 1'b0;
      bm <= '0; bn <= '0; bpl <= '0; freq <= '0;
      div_start <= 1'b0; div_num <= '0; div_den <= '0;
    end else begin
      div_start <= 1'b0;
      case (state)
        ST_IDLE: if (req_valid) begin
          ref_r <= DW'(req_ref_khz); tgt_r <= DW'(req_tgt_khz);
          bf_r <= req_best_fit; found <= 1'b0; bdelta <= '1;
          bm <= MW'(M_MAX); bn <= NW'(N_MIN); bpl <= PW'(PL_MIN);
          state <= ST_D_MARGIN;
        end
        ST_WAIT: if (div_done) state <= ret;
        ST_D_MARGIN: begin
          div_num <= tgt_r; div_den <= DW'(50); div_start <= 1'b1;
          ret <= ST_A_MARGIN; state <= ST_WAIT;
        end
        ST_A_MARGIN: begin
          tvco  <= tgt_r + div_quo;
          vmax  <= (tgt_r + div_quo > VMAX_D) ? tgt_r + div_quo : VMAX_D;
          state <= ST_D_HIGH;
        end
        ST_D_HIGH: begin
          div_num <= vmax; div_den <= tvco; div_start <= 1'b1;
          ret <= ST_A_HIGH; state <= ST_WAIT;
        end
        ST_A_HIGH: begin hi <= clamp_pl(ceil_q); state <= ST_D_LOW; end
        ST_D_LOW: begin
          div_num <= VMIN_D; div_den <= tvco; div_start <= 1'b1;
          ret <= ST_A_LOW; state <= ST_WAIT;
        end
        ST_A_LOW: begin
          pl <= clamp_pl(div_quo); m <= (MW+1)'(M_MIN); state <= ST_D_U;
        end
        ST_D_U: begin
          if (pl > hi) state <= ST_FIN;
          else begin
            div_num <= ref_r; div_den <= DW'(m); div_start <= 1'b1;
            ret <= ST_A_U; state <= ST_WAIT;
          end
        end
        ST_A_U: begin
          if (div_quo < DW'(U_MIN))      state <= ST_NEXT_PL;
          else if (div_quo > DW'(U_MAX)) state <= ST_NEXT_M;
          else                           state <= ST_D_N;
        end
        ST_NEXT_M: begin
          if (m >= (MW+1)'(M_MAX)) state <= ST_NEXT_PL;
          else begin m <= m + 1'b1; state <= ST_D_U; end
        end
        ST_NEXT_PL: begin
          pl <= pl + 1'b1; m <= (MW+1)'(M_MIN); state <= ST_D_U;
        end
        ST_D_N: begin
          div_num <= tgt_r * DW'(pl) * DW'(m); div_den <= ref_r;
          div_start <= 1'b1; ret <= ST_A_N; state <= ST_WAIT;
        end
        ST_A_N: begin
          n <= div_quo; n2 <= ceil_q;
          state <= (div_quo > DW'(N_MAX)) ? ST_NEXT_PL : ST_D_VCO;
        end
        ST_D_VCO: begin
          if (n > n2 || n > DW'(N_MAX)) state <= ST_NEXT_M;
          else if (n < DW'(N_MIN)) n <= n + 1'b1;
          else begin
            div_num <= ref_r * n; div_den <= DW'(m); div_start <= 1'b1;
            ret <= ST_A_VCO; state <= ST_WAIT;
          end
        end
        ST_A_VCO: begin
          vco <= div_quo;
          if (div_quo >= VMIN_D && div_quo <= vmax) state <= ST_D_LWV;
          else begin n <= n + 1'b1; state <= ST_D_VCO; end
        end
        ST_D_LWV: begin
          div_num <= vco + DW'(pl >> 1); div_den <= DW'(pl); div_start <= 1'b1;
          ret <= ST_A_LWV; state <= ST_WAIT;
        end
        ST_A_LWV: begin
          n <= n + 1'b1;
          state <= ST_D_VCO;
          if (delta < bdelta) begin
            bdelta <= delta; found <= 1'b1;
            bm <= m[MW-1:0]; bn <= n[NW-1:0]; bpl <= pl[PW-1:0];
            if (delta == '0 ||
                (!bf_r && XW'(vco) >= STOP_K * XW'(delta)))
              state <= ST_FIN;
          end
        end
        ST_FIN: begin
          if (!found) begin freq <= '0; state <= ST_OUT; end
          else begin
            div_num <= ref_r * DW'(bn);
            div_den <= DW'(bm) * DW'(bpl);
            div_start <= 1'b1; ret <= ST_A_FREQ; state <= ST_WAIT;
          end
        end
        ST_A_FREQ: begin freq <= div_quo[FW-1:0]; state <= ST_OUT; end
        ST_OUT: if (res_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pll_coef_search.sv
module pll_coef_search #(
  parameter int unsigned FW      = 22,
  parameter int unsigned M_MIN   = 1,
  parameter int unsigned M_MAX   = 255,
  parameter int unsigned N_MIN   = 8,
  parameter int unsigned N_MAX   = 255,
  parameter int unsigned PL_MIN  = 1,
  parameter int unsigned PL_MAX  = 31,
  parameter int unsigned VCO_MIN = 1300000,
  parameter int unsigned VCO_MAX = 2600000,
  parameter int unsigned U_MIN   = 12000,
  parameter int unsigned U_MAX   = 38400,
  parameter int unsigned TOL     = 218,
  localparam int unsigned MW     = $clog2(M_MAX + 1),
  localparam int unsigned NW     = $clog2(N_MAX + 1),
  localparam int unsigned PW     = $clog2(PL_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [FW-1:0] req_ref_khz,
  input  logic [FW-1:0] req_tgt_khz,
  input  logic          req_best_fit,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [MW-1:0] res_m,
  output logic [NW-1:0] res_n,
  output logic [PW-1:0] res_pl,
  output logic [FW-1:0] res_freq_khz,
  output logic          res_inexact,
  output logic          res_none
);
  localparam int unsigned DW = FW + MW + PW + 2;

  logic          div_start, div_done;
  logic [DW-1:0] div_num, div_den, div_quo, div_rem;

  pcs_divider #(.DW(DW)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start), .num(div_num),
    .den(div_den), .done(div_done), .quo(div_quo), .rem(div_rem)
  );

  pcs_engine #(
    .FW(FW), .MW(MW), .NW(NW), .PW(PW), .DW(DW),
    .M_MIN(M_MIN), .M_MAX(M_MAX), .N_MIN(N_MIN), .N_MAX(N_MAX),
    .PL_MIN(PL_MIN), .PL_MAX(PL_MAX), .VCO_MIN(VCO_MIN), .VCO_MAX(VCO_MAX),
    .U_MIN(U_MIN), .U_MAX(U_MAX), .TOL(TOL)
  ) u_eng (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_ref_khz(req_ref_khz), .req_tgt_khz(req_tgt_khz),
    .req_best_fit(req_best_fit),
    .res_valid(res_valid), .res_ready(res_ready),
    .res_m(res_m), .res_n(res_n), .res_pl(res_pl),
    .res_freq_khz(res_freq_khz), .res_inexact(res_inexact),
    .res_none(res_none),
    .div_start(div_start), .div_num(div_num), .div_den(div_den),
    .div_done(div_done), .div_quo(div_quo), .div_rem(div_rem)
  );
endmodule

// File: rtl/pcs_chk.sv
module pcs_chk #(
  parameter int unsigned FW = 22, MW = 8, NW = 8, PW = 5,
  parameter int unsigned M_MIN = 1, M_MAX = 255, N_MIN = 8, N_MAX = 255,
  parameter int unsigned PL_MIN = 1, PL_MAX = 31
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          res_valid,
  input logic          res_ready,
  input logic [MW-1:0] res_m,
  input logic [NW-1:0] res_n,
  input logic [PW-1:0] res_pl,
  input logic [FW-1:0] res_freq_khz,
  input logic          res_inexact,
  input logic          res_none
);
  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);
  // R2
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !req_ready);
  // R3
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_m) && $stable(res_n)
      && $stable(res_pl) && $stable(res_freq_khz) && $stable(res_inexact)
      && $stable(res_none));
  // R12
  none_zero_freq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_none |-> res_freq_khz == '0 && !res_inexact);
  // R7
  limits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_none |-> res_m >= MW'(M_MIN) && res_m <= MW'(M_MAX)
      && res_n >= NW'(N_MIN) && res_n <= NW'(N_MAX)
      && res_pl >= PW'(PL_MIN) && res_pl <= PW'(PL_MAX));
endmodule

bind pll_coef_search pcs_chk #(
  .FW(FW), .MW(MW), .NW(NW), .PW(PW), .M_MIN(M_MIN), .M_MAX(M_MAX),
  .N_MIN(N_MIN), .N_MAX(N_MAX), .PL_MIN(PL_MIN), .PL_MAX(PL_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .res_valid(res_valid), .res_ready(res_ready), .res_m(res_m),
  .res_n(res_n), .res_pl(res_pl), .res_freq_khz(res_freq_khz),
  .res_inexact(res_inexact), .res_none(res_none)
);

// File: tb/tb_pll_coef_search.sv
module tb_pll_coef_search;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [21:0] req_ref_khz = '0;
  logic [21:0] req_tgt_khz = '0;
  logic        req_best_fit = 1'b0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [7:0]  res_m;
  logic [7:0]  res_n;
  logic [4:0]  res_pl;
  logic [21:0] res_freq_khz;
  logic        res_inexact;
  logic        res_none;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  pll_coef_search dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_ref_khz(req_ref_khz), .req_tgt_khz(req_tgt_khz),
    .req_best_fit(req_best_fit), .res_valid(res_valid), .res_ready(res_ready),
    .res_m(res_m), .res_n(res_n), .res_pl(res_pl),
    .res_freq_khz(res_freq_khz), .res_inexact(res_inexact),
    .res_none(res_none)
  );

  typedef struct packed {
    int unsigned refk;
    int unsigned tgtk;
    bit          bf;
    int unsigned m;
    int unsigned n;
    int unsigned pl;
    int unsigned freq;
    bit          inex;
    bit          none;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{38400, 1536000, 1'b1, 1,  40, 1, 1536000, 1'b0, 1'b0}, // R4 exact first hit
    '{38400, 1000000, 1'b1, 1,  52, 2,  998400, 1'b1, 1'b0}, // R7 R8 VCO window
    '{38400, 1000000, 1'b0, 1,  52, 2,  998400, 1'b0, 1'b0}, // R9 R11
    '{38400, 1005000, 1'b1, 3, 157, 2, 1004800, 1'b1, 1'b0}, // R8 later better
    '{38400, 1005000, 1'b0, 1,  52, 2,  998400, 1'b0, 1'b0}, // R9 early stop
    '{38400, 2600000, 1'b0, 1,  68, 1, 2611200, 1'b0, 1'b0}, // R5 raised VCO bound
    '{38400, 2600000, 1'b1, 3, 203, 1, 2598400, 1'b1, 1'b0}, // R5 R8
    '{50000, 1500000, 1'b1, 2,  60, 1, 1500000, 1'b0, 1'b0}, // R6 skip fast u
    '{10000, 1000000, 1'b1, 0,   0, 0,       0, 1'b0, 1'b1}  // R6 R12 none
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  task automatic send(input int unsigned rk, input int unsigned tk, input bit bf);
    @(negedge clk);
    req_ref_khz = 22'(rk); req_tgt_khz = 22'(tk); req_best_fit = bf;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R2 busy after accept", int'(req_ready), 0);
  endtask

  task automatic wait_res();
    while (!res_valid) @(negedge clk);
  endtask

  task automatic take_res();
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 req_ready", int'(req_ready), 1);
    chk(res_valid == 1'b0, "R1 res_valid", int'(res_valid), 0);

    for (int i = 0; i < NV; i++) begin
      send(VECS[i].refk, VECS[i].tgtk, VECS[i].bf);
      wait_res();
      chk(res_none == VECS[i].none, "R12 none flag", int'(res_none), int'(VECS[i].none));
      chk(res_freq_khz == 22'(VECS[i].freq), "R10 freq", int'(res_freq_khz), int'(VECS[i].freq));
      chk(res_inexact == VECS[i].inex, "R11 inexact", int'(res_inexact), int'(VECS[i].inex));
      if (!VECS[i].none) begin
        chk(res_m == 8'(VECS[i].m), "R8 M", int'(res_m), int'(VECS[i].m));
        chk(res_n == 8'(VECS[i].n), "R8 N", int'(res_n), int'(VECS[i].n));
        chk(res_pl == 5'(VECS[i].pl), "R8 PL", int'(res_pl), int'(VECS[i].pl));
      end
      take_res();
      chk(req_ready == 1'b1, "R2 ready after result", int'(req_ready), 1);
    end

    // R3: back-pressure holds the result; R2: no new request meanwhile
    send(38400, 1005000, 1'b1);
    wait_res();
    req_valid = 1'b1; req_ref_khz = 22'(50000); req_tgt_khz = 22'(1500000);
    repeat (6) @(negedge clk);
    chk(res_valid == 1'b1, "R3 valid held", int'(res_valid), 1);
    chk(res_m == 8'd3, "R3 M held", int'(res_m), 3);
    chk(res_n == 8'd157, "R3 N held", int'(res_n), 157);
    chk(res_freq_khz == 22'(1004800), "R3 freq held", int'(res_freq_khz), 1004800);
    chk(req_ready == 1'b0, "R2 ready low while result pending", int'(req_ready), 0);
    req_valid = 1'b0;
    take_res();

    // R4: exact hit with M=1 skipped proves the pending request was not taken
    send(50000, 1500000, 1'b0);
    wait_res();
    chk(res_m == 8'd2 && res_n == 8'd60, "R4 R6 exact after skip",
        int'(res_m) * 1000 + int'(res_n), 2060);
    take_res();

    finish_run();
  end
endmodule